// File: doc/BRIEF.md
# Adapter Reset Release Sequencer

This block owns the reset and control bits that a network adapter's glue logic needs before its core can run. On an open request it steps the three active-low reset lines (core, host interface, FIFO) through a fixed pattern. First the core line is released. Then all three lines are pulled low together and held there for a timed interval. After that they are released one at a time, the interrupt enables are switched on, and the FIFO threshold register is loaded.

A close request clears the whole control word in one step, which asserts every reset and drops the interrupt enables. A lighter enable request releases only the core reset and then waits out the same timed interval. This is meant for use before configuration reads.

Every register write takes its own clock cycle. One time unit is `UNIT_CYCLES` clocks, and the hold lasts `HOLD_UNITS` units. A one-cycle done pulse marks the end of each sequence. While a sequence runs, any new request is ignored.

Top module: `adapter_rst_seq`

## Requirements
- R1: After reset, all three reset lines are low, both interrupt enables are low, the threshold output is zero and done is low.
- R2: An open request sampled at clock edge t0 drives core_rst_n high at edge t0+1. At edge t0+2 it drives all three reset lines low.
- R3: After an open request, the core release is written exactly HOLD_UNITS*UNIT_CYCLES+1 cycles after the edge that wrote the all-asserted step.
- R4: During an open, the resets are released on consecutive edges in the order core, then host interface, then FIFO.
- R5: Both interrupt enables (system and bus error) go high together, one edge after the FIFO release.
- R6: One edge after the enables, fifo_thresh is loaded with THRESH_VAL (30 by default), and done rises on that same edge.
- R7: A close request sampled at edge t0 clears every output bit at edge t0+1, and done rises on that same edge.
- R8: An enable request sampled at t0 sets only core_rst_n, at edge t0+1, and leaves every other output unchanged. Done rises HOLD_UNITS*UNIT_CYCLES+1 cycles after that write.
- R9: Done is high for exactly one cycle, once per completed sequence, and is low at all other times.
- R10: Requests that arrive while a sequence is running have no effect. When several requests arrive in the same idle cycle, close wins over open, and open wins over enable.
- R11: The all-asserted step of an open leaves the interrupt enables and fifo_thresh at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_req | input | 1 | Start the full power-up sequence |
| close_req | input | 1 | Clear the whole control word |
| enable_req | input | 1 | Release the core reset only, then wait |
| core_rst_n | output | 1 | Core chip reset, active low |
| host_rst_n | output | 1 | Host interface reset, active low |
| fifo_rst_n | output | 1 | FIFO reset, active low |
| sys_irq_en | output | 1 | System interrupt enable |
| err_irq_en | output | 1 | Bus error interrupt enable |
| fifo_thresh | output | THRESH_W | FIFO threshold register value |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions assume that reset is high from time zero and that the request inputs are synchronous to clk. They also assume the host interface and FIFO reset lines change only through this block's own open and close paths, so a rise on one of them always belongs to an open sequence. The stimulus drives each request as a one-cycle pulse on the falling edge. It lets every sequence run to completion before issuing the next one, except where it deliberately fires extra requests into a running hold interval to show that they are dropped.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CORE_ON,
    OP_ALL_OFF,
    OP_HOST_ON,
    OP_FIFO_ON,
    OP_IRQ_ON,
    OP_THRESH,
    OP_CLEAR
  } wr_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_O_CORE,
    ST_O_ALL,
    ST_O_HOLD,
    ST_O_HOST,
    ST_O_FIFO,
    ST_O_IRQ,
    ST_O_THR,
    ST_CLOSE,
    ST_E_CORE,
    ST_E_HOLD
  } seq_st_e;

  typedef struct packed {
    logic core_n;
    logic host_n;
    logic fifo_n;
    logic sys_ie;
    logic err_ie;
  } ctrl_t;

endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int UNIT_CYCLES = 4,
  parameter int HOLD_UNITS  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int PRE_W  = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam int UNIT_W = (HOLD_UNITS > 1) ? $clog2(HOLD_UNITS) : 1;
  localparam logic [PRE_W-1:0]  LAST_PRE  = PRE_W'(UNIT_CYCLES - 1);
  localparam logic [UNIT_W-1:0] LAST_UNIT = UNIT_W'(HOLD_UNITS - 1);

  logic              running;
  logic [PRE_W-1:0]  pre_cnt;
  logic [UNIT_W-1:0] unit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      pre_cnt  <= '0;
      unit_cnt <= '0;
      expired  <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        running  <= 1'b1;
        pre_cnt  <= '0;
        unit_cnt <= '0;
      end else if (running) begin
        if (pre_cnt == LAST_PRE) begin
          pre_cnt <= '0;
          if (unit_cnt == LAST_UNIT) begin
            running <= 1'b0;
            expired <= 1'b1;
          end else begin
            unit_cnt <= unit_cnt + 1'b1;
          end
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   open_req,
  input  logic   close_req,
  input  logic   enable_req,
  input  logic   tmr_expired,
  output wr_op_e wr_op,
  output logic   tmr_start,
  output logic   done
);
  seq_st_e st, st_nxt;
  logic    fin;

  always_comb begin
    st_nxt    = st;
    wr_op     = OP_NONE;
    tmr_start = 1'b0;
    fin       = 1'b0;
    case (st)
      ST_IDLE: begin
        if (close_req)       st_nxt = ST_CLOSE;
        else if (open_req)   st_nxt = ST_O_CORE;
        else if (enable_req) st_nxt = ST_E_CORE;
      end
      ST_O_CORE: begin
        wr_op  = OP_CORE_ON;
        st_nxt = ST_O_ALL;
      end
      ST_O_ALL: begin
        wr_op     = OP_ALL_OFF;
        tmr_start = 1'b1;
        st_nxt    = ST_O_HOLD;
      end
      ST_O_HOLD: begin
        if (tmr_expired) begin
          wr_op  = OP_CORE_ON;
          st_nxt = ST_O_HOST;
        end
      end
      ST_O_HOST: begin
        wr_op  = OP_HOST_ON;
        st_nxt = ST_O_FIFO;
      end
      ST_O_FIFO: begin
        wr_op  = OP_FIFO_ON;
        st_nxt = ST_O_IRQ;
      end
      ST_O_IRQ: begin
        wr_op  = OP_IRQ_ON;
        st_nxt = ST_O_THR;
      end
      ST_O_THR: begin
        wr_op  = OP_THRESH;
        fin    = 1'b1;
        st_nxt = ST_IDLE;
      end
      ST_CLOSE: begin
        wr_op  = OP_CLEAR;
        fin    = 1'b1;
        st_nxt = ST_IDLE;
      end
      ST_E_CORE: begin
        wr_op     = OP_CORE_ON;
        tmr_start = 1'b1;
        st_nxt    = ST_E_HOLD;
      end
      ST_E_HOLD: begin
        if (tmr_expired) begin
          fin    = 1'b1;
          st_nxt = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_nxt;
      done <= fin;
    end
  end
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
  import rstseq_pkg::*;
#(
  parameter int THRESH_W   = 8,
  parameter int THRESH_VAL = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  wr_op_e              wr_op,
  output ctrl_t               ctrl,
  output logic [THRESH_W-1:0] thresh
);
  localparam logic [THRESH_W-1:0] THR_LOAD = THRESH_W'(THRESH_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      thresh <= '0;
    end else begin
      case (wr_op)
        OP_CORE_ON: ctrl.core_n <= 1'b1;
        OP_ALL_OFF: begin
          ctrl.core_n <= 1'b0;
          ctrl.host_n <= 1'b0;
          ctrl.fifo_n <= 1'b0;
        end
        OP_HOST_ON: ctrl.host_n <= 1'b1;
        OP_FIFO_ON: ctrl.fifo_n <= 1'b1;
        OP_IRQ_ON: begin
          ctrl.sys_ie <= 1'b1;
          ctrl.err_ie <= 1'b1;
        end
        OP_THRESH: thresh <= THR_LOAD;
        OP_CLEAR: begin
          ctrl   <= '0;
          thresh <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adapter_rst_seq.sv
module adapter_rst_seq
  import rstseq_pkg::*;
#(
  parameter int UNIT_CYCLES = 4,
  parameter int HOLD_UNITS  = 100,
  parameter int THRESH_W    = 8,
  parameter int THRESH_VAL  = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                open_req,
  input  logic                close_req,
  input  logic                enable_req,
  output logic                core_rst_n,
  output logic                host_rst_n,
  output logic                fifo_rst_n,
  output logic                sys_irq_en,
  output logic                err_irq_en,
  output logic [THRESH_W-1:0] fifo_thresh,
  output logic                done
);
  wr_op_e wr_op;
  logic   tmr_start;
  logic   tmr_expired;
  ctrl_t  ctrl;

  rstseq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .open_req    (open_req),
    .close_req   (close_req),
    .enable_req  (enable_req),
    .tmr_expired (tmr_expired),
    .wr_op       (wr_op),
    .tmr_start   (tmr_start),
    .done        (done)
  );

  rstseq_timer #(
    .UNIT_CYCLES (UNIT_CYCLES),
    .HOLD_UNITS  (HOLD_UNITS)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .expired (tmr_expired)
  );

  rstseq_regs #(
    .THRESH_W   (THRESH_W),
    .THRESH_VAL (THRESH_VAL)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_op  (wr_op),
    .ctrl   (ctrl),
    .thresh (fifo_thresh)
  );

  assign core_rst_n = ctrl.core_n;
  assign host_rst_n = ctrl.host_n;
  assign fifo_rst_n = ctrl.fifo_n;
  assign sys_irq_en = ctrl.sys_ie;
  assign err_irq_en = ctrl.err_ie;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int HOLD_CYCLES = 400,
  parameter int THR_W       = 8,
  parameter int THR_VAL     = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             core_rst_n,
  input logic             host_rst_n,
  input logic             fifo_rst_n,
  input logic             sys_irq_en,
  input logic             err_irq_en,
  input logic [THR_W-1:0] fifo_thresh,
  input logic             done
);
  logic        all_low;
  logic [31:0] zrun;
  logic [31:0] last_run;

  assign all_low = !core_rst_n && !host_rst_n && !fifo_rst_n;

  // Length of the most recent interval with all three resets low.
  always_ff @(posedge clk) begin
    if (rst) begin
      zrun     <= '0;
      last_run <= '0;
    end else if (all_low) begin
      if (zrun != 32'hFFFF_FFFF) zrun <= zrun + 1;
    end else if (zrun != 0) begin
      last_run <= zrun;
      zrun     <= '0;
    end
  end

  a_r3_hold_window: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rst_n) |-> (last_run >= 32'(HOLD_CYCLES)));

  a_r4_host_after_core: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rst_n) |-> core_rst_n);

  a_r4_fifo_after_host: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_rst_n) |-> (host_rst_n && core_rst_n));

  a_r5_irq_after_fifo: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_irq_en) |-> (fifo_rst_n && err_irq_en));

  a_r6_thresh_value: assert property (@(posedge clk) disable iff (rst)
    !$stable(fifo_thresh) |-> (fifo_thresh == THR_W'(THR_VAL) || fifo_thresh == '0));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind adapter_rst_seq rstseq_chk #(
  .HOLD_CYCLES (HOLD_UNITS * UNIT_CYCLES),
  .THR_W       (THRESH_W),
  .THR_VAL     (THRESH_VAL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .core_rst_n  (core_rst_n),
  .host_rst_n  (host_rst_n),
  .fifo_rst_n  (fifo_rst_n),
  .sys_irq_en  (sys_irq_en),
  .err_irq_en  (err_irq_en),
  .fifo_thresh (fifo_thresh),
  .done        (done)
);

// File: tb/sim_adapter_rst_seq.sv
`timescale 1ns/1ps
module sim_adapter_rst_seq;
  localparam int UNIT = 3;
  localparam int HOLD = 5;
  localparam int N    = UNIT * HOLD;
  localparam int TW   = 8;
  localparam int TVAL = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic open_req = 1'b0, close_req = 1'b0, enable_req = 1'b0;
  logic core_rst_n, host_rst_n, fifo_rst_n, sys_irq_en, err_irq_en, done;
  logic [TW-1:0] fifo_thresh;

  always #5 clk = ~clk;

  adapter_rst_seq #(.UNIT_CYCLES(UNIT), .HOLD_UNITS(HOLD), .THRESH_W(TW), .THRESH_VAL(TVAL)) u0 (
    .clk(clk), .rst(rst), .open_req(open_req), .close_req(close_req), .enable_req(enable_req),
    .core_rst_n(core_rst_n), .host_rst_n(host_rst_n), .fifo_rst_n(fifo_rst_n),
    .sys_irq_en(sys_irq_en), .err_irq_en(err_irq_en), .fifo_thresh(fifo_thresh), .done(done));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Scoreboard: vector {core,host,fifo,sys,err,thresh,done}; gap 0 = any.
  logic [TW+5:0] exp_v[$];
  int            exp_g[$];
  string         exp_t[$];

  logic m_core = 0, m_host = 0, m_fifo = 0, m_sys = 0, m_err = 0, m_done = 0;
  logic [TW-1:0] m_thr = '0;
  logic [TW+5:0] m_vec = '0;
  int pend = 0;
  bit pend_dc = 1'b1;

  function automatic logic [TW+5:0] pack_model();
    return {m_core, m_host, m_fifo, m_sys, m_err, m_thr, m_done};
  endfunction

  function automatic void push_step(string tag, int g);
    logic [TW+5:0] v;
    v = pack_model();
    if (v == m_vec) begin
      pend += g;
    end else begin
      exp_v.push_back(v);
      exp_g.push_back(pend_dc ? 0 : pend + g);
      exp_t.push_back(tag);
      pend = 0;
      pend_dc = 1'b0;
      m_vec = v;
    end
  endfunction

  function automatic void exp_open(string all_tag);
    pend_dc = 1'b1;
    m_core = 1; push_step("R2", 1);
    m_core = 0; m_host = 0; m_fifo = 0; push_step(all_tag, 1);
    m_core = 1; push_step("R3", N + 1);
    m_host = 1; push_step("R4", 1);
    m_fifo = 1; push_step("R4", 1);
    m_sys = 1; m_err = 1; push_step("R5", 1);
    m_thr = TW'(TVAL); m_done = 1; push_step("R6", 1);
    m_done = 0; push_step("R9", 1);
  endfunction

  function automatic void exp_close();
    pend_dc = 1'b1;
    m_core = 0; m_host = 0; m_fifo = 0; m_sys = 0; m_err = 0; m_thr = '0; m_done = 1;
    push_step("R7", 1);
    m_done = 0; push_step("R9", 1);
  endfunction

  function automatic void exp_enable();
    pend_dc = 1'b1;
    m_core = 1; push_step("R8", 1);
    m_done = 1; push_step("R8", N + 1);
    m_done = 0; push_step("R9", 1);
  endfunction

  task automatic check(string tag, logic [TW+5:0] act, logic [TW+5:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: compares every output change against the expected queue.
  logic [TW+5:0] prev_v = '0;
  int last_cyc = 0;
  always @(negedge clk) begin
    logic [TW+5:0] cur;
    cyc++;
    cur = {core_rst_n, host_rst_n, fifo_rst_n, sys_irq_en, err_irq_en, fifo_thresh, done};
    if (!rst && cur !== prev_v) begin
      checks++;
      if (exp_v.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected change actual=%h expected=no change", cur);
      end else begin
        logic [TW+5:0] ev;
        int eg;
        string et;
        ev = exp_v.pop_front();
        eg = exp_g.pop_front();
        et = exp_t.pop_front();
        if (cur !== ev || (eg != 0 && (cyc - last_cyc) != eg)) begin
          errors++;
          $display("FAIL %s actual=%h gap %0d expected=%h gap %0d",
                   et, cur, cyc - last_cyc, ev, eg);
        end
      end
      last_cyc = cyc;
    end
    prev_v = cur;
  end

  task automatic pulse(logic o, logic c, logic e);
    @(negedge clk);
    open_req = o; close_req = c; enable_req = e;
    @(negedge clk);
    open_req = 0; close_req = 0; enable_req = 0;
  endtask

  task automatic settle(string tag);
    repeat (N + 12) @(negedge clk);
    checks++;
    if (exp_v.size() != 0) begin
      errors++;
      $display("FAIL %s actual=%0d pending expected=0 pending", tag, exp_v.size());
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1", {core_rst_n, host_rst_n, fifo_rst_n, sys_irq_en, err_irq_en, fifo_thresh, done}, '0);

    // R8: enable releases core only
    exp_enable();
    pulse(0, 0, 1);
    settle("R8");

    // Open with core already released (R2, R3, R4, R5, R6)
    exp_open("R2");
    pulse(1, 0, 0);
    settle("R6");

    // Second open: all-asserted step keeps enables and threshold (R11)
    exp_open("R11");
    pulse(1, 0, 0);
    settle("R11");

    // R7: close clears all
    exp_close();
    pulse(0, 1, 0);
    settle("R7");

    // R10: requests during the hold are ignored
    exp_open("R2");
    pulse(1, 0, 0);
    repeat (4) @(negedge clk);
    pulse(0, 1, 0);
    pulse(0, 0, 1);
    pulse(1, 0, 0);
    settle("R10");

    // R10: close beats open in the same cycle
    exp_close();
    pulse(1, 1, 0);
    settle("R10");

    // R10: open beats enable in the same cycle
    exp_open("R2");
    pulse(1, 0, 1);
    settle("R10");

    exp_close();
    pulse(0, 1, 0);
    settle("R7");

    @(negedge clk);
    check("R1", {core_rst_n, host_rst_n, fifo_rst_n, sys_irq_en, err_irq_en, fifo_thresh, done}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule